// File: doc/BRIEF.md
# Compressed Sensing Accumulator Array

This block turns a continuous stream of 8-bit converter samples into a small set of random linear measurements. Each accepted sample has its most significant bit inverted, so a mid-scale code reads as zero. It is then added into every accumulator whose bit in a row-select vector is 1. Accumulators whose bit is 0 keep their value, which stands for the -1 entry of a +/-1 matrix. An outside generator supplies the row-select vector once per sample and reloads its seed whenever the block raises a reseed pulse.

The frame length N is a run-time input. After N samples, the next accepted sample snapshots every accumulator into a serial shift register and starts the new frame with its own contribution, so no sample is lost and acquisition never stops. The snapshot streams out one bit per clock, row 0 first and MSB first, as full 16-bit words or as the upper 8 bits only. Two inputs support resolution experiments: one zeroes up to three low input bits, the other halves the output word. Sums saturate at the signed limits, and a flag reports a saturated frame together with that frame's readout.

Top module: `cs_accum_array`

## Requirements
- R1: The sample term is the input code with its MSB inverted, read as a signed 8-bit number (code 8'h80 gives 0, 8'hFF gives +127, 8'h00 gives -128).
- R2: On an accepted sample, accumulator i adds the term when rowSel[i] is 1 and keeps its value when rowSel[i] is 0.
- R3: A frame holds N = frameLen samples (frameLen of 1 or more). The first accepted sample after the N-th snapshots all accumulators for readout and loads accumulator i with its term if rowSel[i] is 1, otherwise with 0. All accumulators start at 0 after reset.
- R4: reseedPulse is high for exactly the one cycle after the N-th sample of each frame is accepted, and low otherwise.
- R5: Accumulators saturate at +32767 and -32768. overflowFlag, valid from the first readout bit of a frame, is 1 when any accumulator saturated during that frame.
- R6: maskBits = k (0 to 3) zeroes the k lowest bits of the input code before the MSB inversion.
- R7: With narrowOut = 1 each row is sent as bits [15:8] of its accumulator (8 bits); with narrowOut = 0 all 16 bits are sent.
- R8: From the clock edge that takes the snapshot, serValid is high for exactly 50 x word-width cycles. serBit carries row 0 first, each word MSB first. frameStart is high only during the first bit.
- R9: overrunFlag becomes 1 if a snapshot is taken while two or more bits of the previous frame remain to be sent, and it stays 1 until reset.
- R10: While sampleValid is low, sampleIn and rowSel have no effect: the sample count and the accumulators do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleIn | input | 8 | Offset-binary converter code |
| sampleValid | input | 1 | Accept sampleIn in this cycle |
| rowSel | input | 50 | Matrix entries for this sample, one per accumulator |
| frameLen | input | 16 | Samples per frame (N), at least 1 |
| maskBits | input | 2 | Number of low input bits forced to zero |
| narrowOut | input | 1 | 1 = send upper 8 bits of each word |
| serBit | output | 1 | Serial measurement data |
| serValid | output | 1 | serBit carries a valid bit |
| frameStart | output | 1 | First bit of a frame |
| overflowFlag | output | 1 | Frame being sent saturated somewhere |
| overrunFlag | output | 1 | Sticky: a snapshot cut a readout short |
| reseedPulse | output | 1 | Reload the matrix generator seed |

## Verification
The assertions assume that frameLen, maskBits and narrowOut stay constant between resets and that frameLen is at least 1. The saturation and hold properties also assume that rowSel and sampleIn are steady during the cycle a sample is accepted. The stimulus changes these settings only while reset is held and drives inputs once per cycle. Except in the one scenario meant to provoke an overrun, it spaces samples so that each readout ends before the next snapshot. Random values on sampleIn and rowSel between accepted samples exercise the rule that unaccepted inputs are ignored.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef struct packed {
    logic accEn;    // a sample is accepted this cycle
    logic capture;  // snapshot accumulators and restart the frame
    logic shiftEn;  // advance the serial register by one bit
  } ctrlStrobes_t;
endpackage

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
#(
  parameter int NUM_ROWS = 50,
  parameter int ACC_W    = 16,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleValid,
  input  logic [CNT_W-1:0] frameLen,
  input  logic             narrowOut,
  output ctrlStrobes_t     strobes,
  output logic             serValid,
  output logic             frameStart,
  output logic             reseedPulse,
  output logic             overrunFlag
);
  localparam int WIDE_BITS   = NUM_ROWS * ACC_W;
  localparam int NARROW_BITS = NUM_ROWS * (ACC_W / 2);
  localparam int BITS_W      = $clog2(WIDE_BITS + 1);

  logic [CNT_W-1:0]  sampleCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic [BITS_W-1:0] bitsLeft;
  logic              isCapture;

  assign isCapture = sampleValid && (sampleCnt == frameLen);
  assign nextCnt   = isCapture ? CNT_W'(1) : sampleCnt + 1'b1;
  assign serValid  = (bitsLeft != '0);

  assign strobes.accEn   = sampleValid;
  assign strobes.capture = isCapture;
  assign strobes.shiftEn = serValid && !isCapture;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sampleCnt   <= '0;
      bitsLeft    <= '0;
      frameStart  <= 1'b0;
      reseedPulse <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      frameStart  <= isCapture;
      reseedPulse <= sampleValid && (nextCnt == frameLen);
      if (sampleValid) sampleCnt <= nextCnt;
      if (isCapture) begin
        bitsLeft <= narrowOut ? BITS_W'(NARROW_BITS) : BITS_W'(WIDE_BITS);
        if (bitsLeft > BITS_W'(1)) overrunFlag <= 1'b1;
      end else if (serValid) begin
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  // R4
  reseed_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reseedPulse |-> $past(sampleValid));
  // R9
  sticky_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrunFlag |=> overrunFlag);
  // R8
  frame_start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> serValid);
  // R8
  serial_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serValid) |-> frameStart);
endmodule

// File: rtl/cs_datapath.sv
module cs_datapath
  import cs_pkg::*;
#(
  parameter int NUM_ROWS = 50,
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 16,
  parameter int MASK_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        strobes,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [MASK_W-1:0]   maskBits,
  input  logic [NUM_ROWS-1:0] rowSel,
  input  logic                narrowOut,
  output logic                serBit,
  output logic                overflowFlag
);
  localparam int NW       = ACC_W / 2;
  localparam int TOT_BITS = NUM_ROWS * ACC_W;
  localparam int PAD_BITS = TOT_BITS - NUM_ROWS * NW;

  logic [SAMPLE_W-1:0]             keepMask, masked, term;
  logic [ACC_W-1:0]                termAcc;
  logic [NUM_ROWS-1:0][ACC_W-1:0]  acc, accNext;
  logic [NUM_ROWS-1:0][ACC_W:0]    sumWide;
  logic [NUM_ROWS-1:0]             rowOvf;
  logic                            frameOvf;
  logic [TOT_BITS-1:0]             wideVec, narrowVec, shiftReg;

  assign keepMask = {SAMPLE_W{1'b1}} << maskBits;
  assign masked   = sampleIn & keepMask;
  assign term     = {~masked[SAMPLE_W-1], masked[SAMPLE_W-2:0]};
  assign termAcc  = {{(ACC_W-SAMPLE_W){term[SAMPLE_W-1]}}, term};

  always_comb begin
    for (int i = 0; i < NUM_ROWS; i++) begin
      sumWide[i] = {acc[i][ACC_W-1], acc[i]} + {termAcc[ACC_W-1], termAcc};
      rowOvf[i]  = 1'b0;
      accNext[i] = acc[i];
      if (strobes.capture) begin
        accNext[i] = rowSel[i] ? termAcc : '0;
      end else if (strobes.accEn && rowSel[i]) begin
        if (sumWide[i][ACC_W] != sumWide[i][ACC_W-1]) begin
          rowOvf[i]  = 1'b1;
          accNext[i] = sumWide[i][ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}}
                                         : {1'b0, {(ACC_W-1){1'b1}}};
        end else begin
          accNext[i] = sumWide[i][ACC_W-1:0];
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ROWS; g++) begin : gPack
      assign wideVec[TOT_BITS-1-g*ACC_W -: ACC_W] = acc[g];
      assign narrowVec[TOT_BITS-1-g*NW -: NW]     = acc[g][ACC_W-1 -: NW];

      // R5
      pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes.accEn && !strobes.capture && rowSel[g] &&
         !acc[g][ACC_W-1] && !term[SAMPLE_W-1]) |=> !acc[g][ACC_W-1]);
      // R5
      neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes.accEn && !strobes.capture && rowSel[g] &&
         acc[g][ACC_W-1] && term[SAMPLE_W-1]) |=> acc[g][ACC_W-1]);
      // R3
      capture_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes.capture && !rowSel[g]) |=> (acc[g] == '0));
    end
    if (PAD_BITS > 0) begin : gPad
      assign narrowVec[PAD_BITS-1:0] = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc          <= '0;
      frameOvf     <= 1'b0;
      overflowFlag <= 1'b0;
      shiftReg     <= '0;
    end else begin
      acc <= accNext;
      if (strobes.capture) begin
        frameOvf     <= 1'b0;
        overflowFlag <= frameOvf;
        shiftReg     <= narrowOut ? narrowVec : wideVec;
      end else begin
        if (|rowOvf) frameOvf <= 1'b1;
        if (strobes.shiftEn) shiftReg <= {shiftReg[TOT_BITS-2:0], 1'b0};
      end
    end
  end

  assign serBit = shiftReg[TOT_BITS-1];

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.accEn |=> $stable(acc));
endmodule

// File: rtl/cs_accum_array.sv
module cs_accum_array
  import cs_pkg::*;
#(
  parameter int NUM_ROWS = 50,
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 16,
  parameter int CNT_W    = 16,
  parameter int MASK_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [NUM_ROWS-1:0] rowSel,
  input  logic [CNT_W-1:0]    frameLen,
  input  logic [MASK_W-1:0]   maskBits,
  input  logic                narrowOut,
  output logic                serBit,
  output logic                serValid,
  output logic                frameStart,
  output logic                overflowFlag,
  output logic                overrunFlag,
  output logic                reseedPulse
);
  ctrlStrobes_t strobes;

  cs_ctrl #(.NUM_ROWS(NUM_ROWS), .ACC_W(ACC_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .frameLen(frameLen),
    .narrowOut(narrowOut), .strobes(strobes), .serValid(serValid),
    .frameStart(frameStart), .reseedPulse(reseedPulse), .overrunFlag(overrunFlag)
  );

  cs_datapath #(.NUM_ROWS(NUM_ROWS), .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W),
                .MASK_W(MASK_W)) uData (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .sampleIn(sampleIn),
    .maskBits(maskBits), .rowSel(rowSel), .narrowOut(narrowOut),
    .serBit(serBit), .overflowFlag(overflowFlag)
  );
endmodule

// File: tb/cs_accum_array_test.sv
module cs_accum_array_test;
  localparam int M = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic [M-1:0] rowSel = '0;
  logic [15:0] frameLen = 16'd4;
  logic [1:0]  maskBits = '0;
  logic        narrowOut = 1'b0;
  logic serBit, serValid, frameStart, overflowFlag, overrunFlag, reseedPulse;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cs_accum_array uut (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .rowSel(rowSel), .frameLen(frameLen), .maskBits(maskBits),
    .narrowOut(narrowOut), .serBit(serBit), .serValid(serValid),
    .frameStart(frameStart), .overflowFlag(overflowFlag),
    .overrunFlag(overrunFlag), .reseedPulse(reseedPulse)
  );

  // model state
  int          mAcc[M];
  int          mCnt;
  bit          mOvf;
  logic [15:0] expQ[$];
  bit          ovfQ[$];
  string       phaseTag = "R1 R2 R10";
  bit          checkSer = 1'b1;

  // monitor state
  int          bitPos;
  int          wordIdx;
  logic [15:0] shiftWord;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < M; i++) mAcc[i] = 0;
    mCnt = 0; mOvf = 0;
    expQ.delete(); ovfQ.delete();
    bitPos = 0; wordIdx = 0; shiftWord = '0;
    rst_n = 1'b1;
  endtask

  // driver: applies one sample, updates the model, checks the reseed pulse
  task automatic sendSample(input logic [7:0] code, input logic [M-1:0] sel, input int gap);
    logic [7:0] mk;
    int term, sum, nextCnt;
    bit expReseed;
    @(negedge clk);
    sampleIn = code; rowSel = sel; sampleValid = 1'b1;
    mk = code & (8'hFF << maskBits);
    term = int'($signed({~mk[7], mk[6:0]}));
    if (mCnt == int'(frameLen)) begin
      for (int i = 0; i < M; i++) begin
        expQ.push_back(narrowOut ? {8'h00, mAcc[i][15:8]} : mAcc[i][15:0]);
        mAcc[i] = sel[i] ? term : 0;
      end
      ovfQ.push_back(mOvf);
      mOvf = 0;
      nextCnt = 1;
    end else begin
      for (int i = 0; i < M; i++) begin
        if (sel[i]) begin
          sum = mAcc[i] + term;
          if (sum > 32767) begin sum = 32767; mOvf = 1; end
          if (sum < -32768) begin sum = -32768; mOvf = 1; end
          mAcc[i] = sum;
        end
      end
      nextCnt = mCnt + 1;
    end
    expReseed = (nextCnt == int'(frameLen));
    mCnt = nextCnt;
    @(negedge clk);
    sampleValid = 1'b0;
    check(reseedPulse == expReseed, "R4", int'(reseedPulse), int'(expReseed));
    for (int k = 0; k < gap; k++) begin
      // R10: unaccepted inputs change freely
      sampleIn = 8'($urandom);
      rowSel = {$urandom, $urandom};
      @(negedge clk);
      check(reseedPulse == 1'b0, "R4", int'(reseedPulse), 0);
    end
  endtask

  // monitor: pops expected words as serial data arrives
  always @(negedge clk) begin
    if (rst_n && checkSer && serValid) begin
      int wordW;
      wordW = narrowOut ? 8 : 16;
      if (bitPos == 0 && wordIdx == 0) begin
        check(frameStart == 1'b1, "R8", int'(frameStart), 1);
        if (ovfQ.size() > 0) begin
          bit eo;
          eo = ovfQ.pop_front();
          check(overflowFlag == eo, "R5", int'(overflowFlag), int'(eo));
        end
      end else begin
        check(frameStart == 1'b0, "R8", int'(frameStart), 0);
      end
      shiftWord = {shiftWord[14:0], serBit};
      bitPos++;
      if (bitPos == wordW) begin
        logic [15:0] ew, aw;
        aw = narrowOut ? {8'h00, shiftWord[7:0]} : shiftWord;
        if (expQ.size() == 0) begin
          check(1'b0, "R8", int'(aw), -1);
        end else begin
          ew = expQ.pop_front();
          check(aw == ew, phaseTag, int'(aw), int'(ew));
        end
        bitPos = 0; shiftWord = '0;
        wordIdx = (wordIdx == M - 1) ? 0 : wordIdx + 1;
      end
    end
  end

  task automatic runFrames(input int frames, input int gap);
    for (int s = 0; s < frames * int'(frameLen) + 1; s++)
      sendSample(8'($urandom), {$urandom, $urandom}, gap);
    repeat (900) @(negedge clk);
    check(expQ.size() == 0, "R3", expQ.size(), 0);
    check(serValid == 1'b0, "R8", int'(serValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    check(serValid == 1'b0, "R8", int'(serValid), 0);
    check(reseedPulse == 1'b0, "R4", int'(reseedPulse), 0);
    check(overrunFlag == 1'b0, "R9", int'(overrunFlag), 0);
    check(overflowFlag == 1'b0, "R5", int'(overflowFlag), 0);

    // R1 R2 R3: known codes first, then random ones
    frameLen = 16'd16; maskBits = 2'd0; narrowOut = 1'b0;
    phaseTag = "R1 R2 R10";
    doReset();
    sendSample(8'h80, {M{1'b1}}, 60);
    sendSample(8'hFF, {{(M-1){1'b0}}, 1'b1}, 60);
    sendSample(8'h00, {1'b1, {(M-1){1'b0}}}, 60);
    runFrames(4, 60);
    check(overrunFlag == 1'b0, "R9", int'(overrunFlag), 0);

    // R6: three low bits masked
    frameLen = 16'd12; maskBits = 2'd3; phaseTag = "R6";
    doReset();
    runFrames(3, 70);

    // R7: narrow words
    frameLen = 16'd8; maskBits = 2'd0; narrowOut = 1'b1; phaseTag = "R7";
    doReset();
    runFrames(3, 60);

    // R3 with frame length one: every sample is a frame
    frameLen = 16'd1; narrowOut = 1'b0; phaseTag = "R3";
    doReset();
    runFrames(3, 820);

    // R5: saturation on even rows, then a clean frame
    frameLen = 16'd420; phaseTag = "R5";
    doReset();
    for (int s = 0; s < 420; s++) begin
      logic [M-1:0] ev;
      for (int i = 0; i < M; i++) ev[i] = (i % 2 == 0);
      sendSample(8'hFF, ev, 0);
    end
    for (int s = 0; s < 421; s++) sendSample(8'($urandom_range(120, 136)), {$urandom, $urandom}, 0);
    repeat (900) @(negedge clk);
    check(expQ.size() == 0, "R5", expQ.size(), 0);

    // R9: snapshots faster than readout
    checkSer = 1'b0;
    frameLen = 16'd2;
    doReset();
    check(overrunFlag == 1'b0, "R9", int'(overrunFlag), 0);
    for (int s = 0; s < 10; s++) sendSample(8'($urandom), {$urandom, $urandom}, 0);
    check(overrunFlag == 1'b1, "R9", int'(overrunFlag), 1);
    repeat (20) @(negedge clk);
    check(overrunFlag == 1'b1, "R9", int'(overrunFlag), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule